// File: doc/BRIEF.md
# TxD Minimum-Width Pulse Shaper

This block sits on the serial transmit input, which a sample clock oversamples. A compression stage further down expects every bit to last at least `MIN_RUN` sample periods. The default of ten samples sets the top data rate at one tenth of the sample clock. Jitter and small frequency errors on the line can produce bits slightly shorter than that, and this block removes them.

The raw input first passes through a two-flop synchroniser. The block then measures each constant-level run of the synchronised signal and saturates the measurement at `MIN_RUN`. Completed runs enter a short queue. A player drives the shaped output from this queue and holds every level for at least `MIN_RUN` samples. When a short run is stretched, the edges that follow it move later in time. None of them is lost.

Each stretch raises a one-cycle flag. Stretching is limited to `MAX_STREAK` consecutive short bits. After that limit, or when the queue of pending runs overflows, the player drops its backlog and snaps to the live synchronised level. A long run absorbs any accumulated delay, because the player keeps it only as long as needed to reach the minimum.

Top module: `txd_pulse_shaper`

## Requirements
- R1: With no backlog, a level change on `txd_raw` appears on `txd_shaped` after exactly four rising edges of `clk_smp`.
- R2: While `rst_n` is low and after reset, `txd_shaped` is 1 (idle high) and `stretch_pulse` is 0.
- R3: A run of `MIN_RUN` (10) or more samples reaches the output with its length unchanged when no backlog exists. The output changes level only when a queued run completes or a resync occurs.
- R4: A run shorter than `MIN_RUN` is held on the output for exactly `MIN_RUN` samples. `stretch_pulse` is high for one cycle, in the same cycle the stretched level ends, and never in two adjacent cycles.
- R5: Edges that follow a stretched run are delayed, not dropped, and keep their order.
- R6: When the third consecutive short run (`MAX_STREAK` = 3) ends, the output takes the current synchronised input level, all pending runs are discarded and the short-run count returns to zero. That third short run still raises `stretch_pulse`.
- R7: A run of `MIN_RUN` or more samples leaving the output clears the consecutive short-run count.
- R8: When a run completes while `QDEPTH` (4) runs are already pending and none leaves in that cycle, the block resyncs as in R6. The number of pending runs never exceeds `QDEPTH`.
- R9: A queued run of `MIN_RUN` or more samples is played for only `MIN_RUN` samples once its end is known. This absorbs earlier delay, so latency returns to the four cycles of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_smp | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| txd_raw | input | 1 | Unsynchronised serial transmit data, idle high |
| txd_shaped | output | 1 | Shaped transmit data with minimum run length enforced |
| stretch_pulse | output | 1 | One-cycle pulse when a short run is stretched |

## Verification
The bench builds the block with `MIN_RUN` = 10, `MAX_STREAK` = 3 and `QDEPTH` = 4. The shallow queue lets a burst of twelve one-sample toggles reach the overflow resync. Three short runs of two samples reach the streak resync. Directed runs of three samples separated by long runs exercise streak clearing and delay absorption. A long pseudo-random sequence of run lengths from 1 to 20 mixes all of these paths. A behavioural model built from queues and integers predicts both outputs on every cycle.

// File: rtl/shp_pkg.sv
package shp_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_ADVANCE = 2'd1,
    ACT_RESYNC  = 2'd2
  } shp_act_e;

endpackage

// File: rtl/shp_sync.sv
module shp_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic changed
);

  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      last_q <= 1'b1;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign level   = sync_q;
  assign changed = sync_q ^ last_q;

endmodule

// File: rtl/shp_meter.sv
module shp_meter #(
  parameter int MIN_RUN = 10,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          changed,
  output logic [CW-1:0] run_len,
  output logic [CW-1:0] run_next
);

  localparam logic [CW-1:0] SAT = CW'(MIN_RUN);

  logic [CW-1:0] len_q;

  always_comb begin
    if (changed)
      run_next = CW'(1);
    else if (len_q == SAT)
      run_next = SAT;
    else
      run_next = len_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      len_q <= SAT;
    else
      len_q <= run_next;
  end

  assign run_len = len_q;

endmodule

// File: rtl/shp_fifo.sv
module shp_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  parameter int NW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  input  logic          flush,
  output logic [W-1:0]  head,
  output logic          not_empty,
  output logic          full,
  output logic [NW-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  assign full      = (cnt_q == NW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign wr_ok     = push && (!full || pop) && !flush;
  assign rd_ok     = pop && not_empty && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + AW'(1);
      if (rd_ok) rd_d = (rd_q == LAST) ? '0 : rd_q + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + NW'(1);
        2'b01:   cnt_d = cnt_q - NW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_ok && (wr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) mem[i] <= wdata;
    end
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

endmodule

// File: rtl/shp_player.sv
module shp_player
  import shp_pkg::*;
#(
  parameter int MIN_RUN    = 10,
  parameter int MAX_STREAK = 3,
  parameter int CW         = 4,
  parameter int SW         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live_lvl,
  input  logic          run_end,
  input  logic [CW-1:0] run_next,
  input  logic [CW-1:0] q_head,
  input  logic          q_valid,
  input  logic          q_full,
  output logic          q_pop,
  output logic          q_flush,
  output logic          shaped,
  output logic          stretch,
  output logic [SW-1:0] streak
);

  localparam logic [CW-1:0] SAT      = CW'(MIN_RUN);
  localparam logic [SW-1:0] LAST_STK = SW'(MAX_STREAK - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] hold_q, hold_d;
  logic [SW-1:0] stk_q, stk_d;
  logic          flag_q, flag_d;
  logic          at_min, is_short, overflow, last_short, hold_en;
  shp_act_e      act;

  assign at_min     = (hold_q == SAT);
  assign q_pop      = q_valid && at_min;
  assign is_short   = q_pop && (q_head < SAT);
  assign overflow   = run_end && !q_pop && q_full;
  assign last_short = is_short && (stk_q == LAST_STK);
  assign q_flush    = overflow || last_short;

  always_comb begin
    if (q_flush)    act = ACT_RESYNC;
    else if (q_pop) act = ACT_ADVANCE;
    else            act = ACT_HOLD;
  end

  always_comb begin
    lvl_d  = lvl_q;
    hold_d = hold_q;
    stk_d  = stk_q;
    flag_d = is_short;
    case (act)
      ACT_RESYNC: begin
        lvl_d  = live_lvl;
        hold_d = run_next;
        stk_d  = '0;
      end
      ACT_ADVANCE: begin
        lvl_d  = ~lvl_q;
        hold_d = CW'(1);
        stk_d  = is_short ? stk_q + SW'(1) : '0;
      end
      default: begin
        hold_d = hold_q + CW'(1);
      end
    endcase
  end

  assign hold_en = !((act == ACT_HOLD) && at_min);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      hold_q <= SAT;
      stk_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      stk_q  <= stk_d;
      flag_q <= flag_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign shaped  = lvl_q;
  assign stretch = flag_q;
  assign streak  = stk_q;

endmodule

// File: rtl/txd_pulse_shaper.sv
module txd_pulse_shaper #(
  parameter int MIN_RUN    = 10,
  parameter int MAX_STREAK = 3,
  parameter int QDEPTH     = 4
) (
  input  logic clk_smp,
  input  logic rst_n,
  input  logic txd_raw,
  output logic txd_shaped,
  output logic stretch_pulse
);

  localparam int CW = $clog2(MIN_RUN + 1);
  localparam int SW = (MAX_STREAK > 1) ? $clog2(MAX_STREAK + 1) : 1;
  localparam int NW = $clog2(QDEPTH + 1);

  logic          live_lvl, run_end;
  logic [CW-1:0] run_len, run_next, q_head;
  logic          q_valid, q_full, q_pop, q_flush;
  logic [NW-1:0] q_count;
  logic [SW-1:0] streak;

  shp_sync u_sync (
    .clk     (clk_smp),
    .rst_n   (rst_n),
    .din     (txd_raw),
    .level   (live_lvl),
    .changed (run_end)
  );

  shp_meter #(.MIN_RUN(MIN_RUN), .CW(CW)) u_meter (
    .clk      (clk_smp),
    .rst_n    (rst_n),
    .changed  (run_end),
    .run_len  (run_len),
    .run_next (run_next)
  );

  shp_fifo #(.DEPTH(QDEPTH), .W(CW), .NW(NW)) u_fifo (
    .clk       (clk_smp),
    .rst_n     (rst_n),
    .push      (run_end),
    .wdata     (run_len),
    .pop       (q_pop),
    .flush     (q_flush),
    .head      (q_head),
    .not_empty (q_valid),
    .full      (q_full),
    .count     (q_count)
  );

  shp_player #(
    .MIN_RUN(MIN_RUN), .MAX_STREAK(MAX_STREAK), .CW(CW), .SW(SW)
  ) u_player (
    .clk      (clk_smp),
    .rst_n    (rst_n),
    .live_lvl (live_lvl),
    .run_end  (run_end),
    .run_next (run_next),
    .q_head   (q_head),
    .q_valid  (q_valid),
    .q_full   (q_full),
    .q_pop    (q_pop),
    .q_flush  (q_flush),
    .shaped   (txd_shaped),
    .stretch  (stretch_pulse),
    .streak   (streak)
  );

endmodule

// File: rtl/txd_pulse_shaper_chk.sv
module txd_pulse_shaper_chk #(
  parameter int MAX_STREAK = 3,
  parameter int QDEPTH     = 4,
  parameter int SW         = 2,
  parameter int NW         = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shaped,
  input logic          stretch,
  input logic          pop,
  input logic          flush,
  input logic [SW-1:0] streak,
  input logic [NW-1:0] q_count
);

  // R4
  stretch_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |-> $past(pop));

  // R4
  stretch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |=> !stretch);

  // R6
  streak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    streak < SW'(MAX_STREAK));

  // R8
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= NW'(QDEPTH));

  // R6
  resync_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (q_count == '0) && (streak == '0));

  // R3
  level_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shaped != $past(shaped)) |-> $past(pop || flush));

endmodule

bind txd_pulse_shaper txd_pulse_shaper_chk #(
  .MAX_STREAK(MAX_STREAK), .QDEPTH(QDEPTH), .SW(SW), .NW(NW)
) u_chk (
  .clk     (clk_smp),
  .rst_n   (rst_n),
  .shaped  (txd_shaped),
  .stretch (stretch_pulse),
  .pop     (q_pop),
  .flush   (q_flush),
  .streak  (streak),
  .q_count (q_count)
);

// File: tb/txd_pulse_shaper_tb.sv
module txd_pulse_shaper_tb;

  localparam int MINR = 10;
  localparam int MAXS = 3;
  localparam int QD   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic rx;
  logic y, fl;

  int    errors = 0;
  int    checks = 0;
  int    flags_seen = 0;
  bit    done = 1'b0;
  string tag = "R2";

  always #2 clk = ~clk;

  txd_pulse_shaper #(.MIN_RUN(MINR), .MAX_STREAK(MAXS), .QDEPTH(QD)) u_dut (
    .clk_smp       (clk),
    .rst_n         (rst_n),
    .txd_raw       (rx),
    .txd_shaped    (y),
    .stretch_pulse (fl)
  );

  // behavioural reference
  int m1, m2, md, mc, pc, streak;
  bit my, mflag;
  int q[$];

  always @(posedge clk or negedge rst_n) begin
    bit e, pop, shrt, ovf, snap;
    int mcn;
    if (!rst_n) begin
      m1 = 1; m2 = 1; md = 1; mc = MINR; pc = MINR; streak = 0;
      my = 1'b1; mflag = 1'b0; q.delete();
    end else begin
      e    = (m2 != md);
      mcn  = e ? 1 : ((mc >= MINR) ? MINR : mc + 1);
      pop  = (q.size() > 0) && (pc >= MINR);
      shrt = pop && (q[0] < MINR);
      ovf  = e && !pop && (q.size() == QD);
      snap = ovf || (shrt && streak == MAXS - 1);
      mflag = shrt;
      if (snap) begin
        q.delete();
        my = m2[0];
        pc = mcn;
        streak = 0;
      end else begin
        if (pop) begin
          void'(q.pop_front());
          my = ~my;
          pc = 1;
          streak = shrt ? streak + 1 : 0;
        end else begin
          pc = (pc >= MINR) ? MINR : pc + 1;
        end
        if (e) q.push_back(mc);
      end
      md = m2; m2 = m1; m1 = int'(rx); mc = mcn;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (y !== my || fl !== mflag) begin
        errors++;
        $display("FAIL %s: shaped=%b stretch=%b expected shaped=%b stretch=%b",
                 tag, y, fl, my, mflag);
      end
      if (fl === 1'b1) flags_seen++;
    end
  end

  task automatic check_val(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic run(input bit lvl, input int n);
    rx = lvl;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R1: watchdog expired, got 200000 cycles expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    rst_n = 1'b0;
    rx = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R2 reset shaped", int'(y), 1);
    check_val("R2 reset stretch", int'(fl), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R2 after reset", int'(y), 1);

    tag = "R3";
    run(1, 20); run(0, 12); run(1, 15); run(0, 25); run(1, 30);

    tag = "R1";
    rx = 1'b0;
    repeat (3) @(negedge clk);
    check_val("R1 before 4th edge", int'(y), 1);
    @(negedge clk);
    check_val("R1 at 4th edge", int'(y), 0);
    run(0, 20); run(1, 30);

    tag = "R4";
    flags_seen = 0;
    run(0, 4); run(1, 40);
    check_val("R4 stretch count", flags_seen, 1);

    tag = "R6";
    flags_seen = 0;
    run(0, 2); run(1, 2); run(0, 2); run(1, 40);
    check_val("R6 stretch count", flags_seen, 3);
    check_val("R6 realigned level", int'(y), 1);

    tag = "R7";
    flags_seen = 0;
    run(0, 3); run(1, 3); run(0, 12); run(1, 3); run(0, 3); run(1, 40);
    check_val("R7 stretch count", flags_seen, 4);

    tag = "R9";
    run(0, 3); run(1, 3); run(0, 30);
    check_val("R9 long low shown", int'(y), 0);
    rx = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R9 delay absorbed before", int'(y), 0);
    @(negedge clk);
    check_val("R9 delay absorbed at 4th edge", int'(y), 1);
    run(1, 30);

    tag = "R8";
    for (int i = 0; i < 12; i++) run(i[0], 1);
    run(1, 40);
    check_val("R8 level after overflow", int'(y), 1);

    tag = "R5";
    lfsr = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run(k[0], 1 + int'(lfsr % 16'd20));
    end
    run(1, 60);
    check_val("R5 final level", int'(y), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule